// File: doc/BRIEF.md
# Indexed Host Window onto a Packet Buffer

This block puts a packet-buffer SRAM and a few byte registers behind a narrow strobe bus. The host sees only two ports, told apart by a command-type input. An access to the index port stores or returns a byte-wide offset. An access to the data port then acts on whatever that offset names. Most offsets name ordinary byte registers. A few offsets turn the data port into a window onto the SRAM, through a read pointer and a write pointer that the block keeps itself.

Two SRAM offsets read the buffer. One returns the byte or word at the read pointer and leaves the pointer where it is, so software can look at a location before it consumes it. The other returns the same location and then moves the pointer on. Two more offsets write the buffer, one with a pointer step and one without. A strap input picks the bus width. When the strap is high the bus is 8 bits wide and the pointers step by one byte. When it is low the bus is 16 bits wide and they step by two. Both pointers wrap at the buffer size, and software can load or read back either one a byte at a time.

Top module: `pktbuf_index_port`

## Requirements
- R1: A write with `cmdSel` low stores `hostDin[7:0]` as the current offset. A read with `cmdSel` low returns that offset on `hostDout[7:0]`, with the upper byte zero.
- R2: A data write at offset F6h stores to the SRAM at the write pointer and leaves the write pointer unchanged.
- R3: A data write at offset F8h stores to the SRAM at the write pointer and then advances the write pointer by one step.
- R4: A data read at offset F0h returns SRAM data at the read pointer and leaves the read pointer unchanged. A later read at F2h therefore returns the same location.
- R5: A data read at offset F2h returns SRAM data at the read pointer and then advances the read pointer by one step.
- R6: The read pointer is reached at F4h (bits 7:0) and F5h (bits above 7). The write pointer is reached at FAh (bits 7:0) and FBh (bits above 7). Both pointers reset to zero. Pointer bits at or above `ADDR_W` read as zero.
- R7: When `busWidth8` is high the step is 1, and a memory read returns the byte selected by pointer bit 0 (0 selects the low lane) on `hostDout[7:0]`. A memory write in this mode enables only that lane: `sramBe` bit 0 is the low lane. When `busWidth8` is low the step is 2 and whole 16-bit words move.
- R8: Both pointers wrap modulo 2^`ADDR_W` bytes when they advance.
- R9: Offsets 00h to `STUB_DEPTH`-1 are plain byte registers that can be written and read back. They reset to zero, and the upper byte of a data read from them is zero.
- R10: A data-port read at any other offset, F1h included, returns zero. A write to such an offset changes no register, no pointer and no SRAM location.
- R11: During reset `hostDout` is zero, the offset is zero and `sramWe` is low. `sramWe` is high only during a data write at F6h or F8h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busWidth8 | input | 1 | Width strap: 1 selects the 8-bit bus, 0 the 16-bit bus |
| csN | input | 1 | Chip select, active low |
| rdN | input | 1 | Read strobe, active low |
| wrN | input | 1 | Write strobe, active low |
| cmdSel | input | 1 | 0 selects the index port, 1 the data port |
| hostDin | input | 16 | Write data from the host |
| hostDout | output | 16 | Registered read data to the host |
| sramAddr | output | ADDR_W-1 | SRAM word address |
| sramWe | output | 1 | SRAM write enable |
| sramBe | output | 2 | SRAM byte-lane enables |
| sramWdata | output | 16 | SRAM write data |
| sramRdata | input | 16 | SRAM read data, one cycle after the address |

## Verification
The checks assume the host holds each strobe low for one clock and follows it with at least one idle clock. They also assume read and write are never asserted together, and that the width strap changes only while reset is applied. The gap guarantees that the SRAM has been addressed by the current read pointer for a full cycle before any read is sampled. The stimulus tasks always insert that idle cycle and assert one strobe at a time. The strap is switched from 16-bit to 8-bit only inside a reset pulse.

// File: rtl/pktbuf_port_pkg.sv
package pktbuf_port_pkg;
  localparam logic [7:0] OFS_PEEK   = 8'hF0;
  localparam logic [7:0] OFS_POP    = 8'hF2;
  localparam logic [7:0] OFS_RPLO   = 8'hF4;
  localparam logic [7:0] OFS_RPHI   = 8'hF5;
  localparam logic [7:0] OFS_PUTX   = 8'hF6;
  localparam logic [7:0] OFS_PUT    = 8'hF8;
  localparam logic [7:0] OFS_WPLO   = 8'hFA;
  localparam logic [7:0] OFS_WPHI   = 8'hFB;

  typedef struct packed {
    logic idxWr;
    logic idxRd;
    logic regWr;
    logic regRd;
    logic memWr;
    logic memRd;
    logic advance;
  } portStrobe_t;
endpackage

// File: rtl/pktbuf_port_ctrl.sv
module pktbuf_port_ctrl
  import pktbuf_port_pkg::*;
(
  input  logic        csN,
  input  logic        rdN,
  input  logic        wrN,
  input  logic        cmdSel,
  input  logic [7:0]  index,
  output portStrobe_t strobe
);
  logic rdAcc, wrAcc, isMemRdOfs, isMemWrOfs;

  assign rdAcc = !csN && !rdN && wrN;
  assign wrAcc = !csN && !wrN && rdN;
  assign isMemRdOfs = (index == OFS_PEEK) || (index == OFS_POP);
  assign isMemWrOfs = (index == OFS_PUTX) || (index == OFS_PUT);

  always_comb begin
    strobe.idxWr   = wrAcc && !cmdSel;
    strobe.idxRd   = rdAcc && !cmdSel;
    strobe.memRd   = rdAcc && cmdSel && isMemRdOfs;
    strobe.regRd   = rdAcc && cmdSel && !isMemRdOfs;
    strobe.memWr   = wrAcc && cmdSel && isMemWrOfs;
    strobe.regWr   = wrAcc && cmdSel && !isMemWrOfs;
    strobe.advance = (rdAcc && cmdSel && index == OFS_POP) ||
                     (wrAcc && cmdSel && index == OFS_PUT);
  end
endmodule

// File: rtl/pktbuf_port_dp.sv
module pktbuf_port_dp
  import pktbuf_port_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int STUB_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWidth8,
  input  portStrobe_t       strobe,
  input  logic [15:0]       hostDin,
  output logic [15:0]       hostDout,
  output logic [7:0]        index,
  output logic [ADDR_W-1:0] rdPtr,
  output logic [ADDR_W-1:0] wrPtr,
  output logic [ADDR_W-2:0] sramAddr,
  output logic              sramWe,
  output logic [1:0]        sramBe,
  output logic [15:0]       sramWdata,
  input  logic [15:0]       sramRdata
);
  localparam int SW     = $clog2(STUB_DEPTH);
  localparam int HI_PAD = 16 - ADDR_W;

  logic [ADDR_W-1:0] stepVal;
  logic [7:0]        stubRd [STUB_DEPTH];
  logic [7:0]        regVal;
  logic [15:0]       memVal;

  assign stepVal = busWidth8 ? ADDR_W'(1) : ADDR_W'(2);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) index <= '0;
    else if (strobe.idxWr) index <= hostDin[7:0];
  end

  genvar g;
  for (g = 0; g < STUB_DEPTH; g++) begin : gStub
    logic [7:0] q;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) q <= '0;
      else if (strobe.regWr && index == 8'(g)) q <= hostDin[7:0];
    end
    assign stubRd[g] = q;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdPtr <= '0;
    else if (strobe.regWr && index == OFS_RPLO) rdPtr[7:0] <= hostDin[7:0];
    else if (strobe.regWr && index == OFS_RPHI) rdPtr[ADDR_W-1:8] <= hostDin[ADDR_W-9:0];
    else if (strobe.memRd && strobe.advance) rdPtr <= rdPtr + stepVal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wrPtr <= '0;
    else if (strobe.regWr && index == OFS_WPLO) wrPtr[7:0] <= hostDin[7:0];
    else if (strobe.regWr && index == OFS_WPHI) wrPtr[ADDR_W-1:8] <= hostDin[ADDR_W-9:0];
    else if (strobe.memWr && strobe.advance) wrPtr <= wrPtr + stepVal;
  end

  always_comb begin
    regVal = '0;
    if (index < 8'(STUB_DEPTH)) regVal = stubRd[index[SW-1:0]];
    else begin
      case (index)
        OFS_RPLO: regVal = rdPtr[7:0];
        OFS_RPHI: regVal = {{HI_PAD{1'b0}}, rdPtr[ADDR_W-1:8]};
        OFS_WPLO: regVal = wrPtr[7:0];
        OFS_WPHI: regVal = {{HI_PAD{1'b0}}, wrPtr[ADDR_W-1:8]};
        default:  regVal = '0;
      endcase
    end
  end

  assign memVal = busWidth8 ? {8'h00, (rdPtr[0] ? sramRdata[15:8] : sramRdata[7:0])}
                            : sramRdata;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) hostDout <= '0;
    else if (strobe.idxRd) hostDout <= {8'h00, index};
    else if (strobe.memRd) hostDout <= memVal;
    else if (strobe.regRd) hostDout <= {8'h00, regVal};
  end

  assign sramWe    = strobe.memWr;
  assign sramAddr  = strobe.memWr ? wrPtr[ADDR_W-1:1] : rdPtr[ADDR_W-1:1];
  assign sramWdata = busWidth8 ? {hostDin[7:0], hostDin[7:0]} : hostDin;
  assign sramBe    = busWidth8 ? (wrPtr[0] ? 2'b10 : 2'b01) : 2'b11;
endmodule

// File: rtl/pktbuf_index_port.sv
module pktbuf_index_port
  import pktbuf_port_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int STUB_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWidth8,
  input  logic              csN,
  input  logic              rdN,
  input  logic              wrN,
  input  logic              cmdSel,
  input  logic [15:0]       hostDin,
  output logic [15:0]       hostDout,
  output logic [ADDR_W-2:0] sramAddr,
  output logic              sramWe,
  output logic [1:0]        sramBe,
  output logic [15:0]       sramWdata,
  input  logic [15:0]       sramRdata
);
  portStrobe_t       strobe;
  logic [7:0]        index;
  logic [ADDR_W-1:0] rdPtr;
  logic [ADDR_W-1:0] wrPtr;

  pktbuf_port_ctrl u_ctrl (
    .csN(csN), .rdN(rdN), .wrN(wrN), .cmdSel(cmdSel),
    .index(index), .strobe(strobe)
  );

  pktbuf_port_dp #(.ADDR_W(ADDR_W), .STUB_DEPTH(STUB_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .busWidth8(busWidth8), .strobe(strobe),
    .hostDin(hostDin), .hostDout(hostDout), .index(index),
    .rdPtr(rdPtr), .wrPtr(wrPtr), .sramAddr(sramAddr), .sramWe(sramWe),
    .sramBe(sramBe), .sramWdata(sramWdata), .sramRdata(sramRdata)
  );
endmodule

// File: rtl/pktbuf_index_port_chk.sv
module pktbuf_index_port_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWidth8,
  input logic              csN,
  input logic              rdN,
  input logic              wrN,
  input logic              cmdSel,
  input logic [7:0]        index,
  input logic [ADDR_W-1:0] rdPtr,
  input logic [ADDR_W-1:0] wrPtr,
  input logic              sramWe,
  input logic [1:0]        sramBe,
  input logic [15:0]       hostDout
);
  logic              rdA, wrA;
  logic [ADDR_W-1:0] stepVal, rdNext, wrNext;

  assign rdA     = !csN && !rdN && wrN && cmdSel;
  assign wrA     = !csN && !wrN && rdN && cmdSel;
  assign stepVal = busWidth8 ? ADDR_W'(1) : ADDR_W'(2);
  assign rdNext  = rdPtr + stepVal;
  assign wrNext  = wrPtr + stepVal;

  // R2
  put_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrA && index == 8'hF6) |=> $stable(wrPtr));

  // R3
  put_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrA && index == 8'hF8) |=> (wrPtr == $past(wrNext)));

  // R4
  peek_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdA && index == 8'hF0) |=> $stable(rdPtr));

  // R5
  pop_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdA && index == 8'hF2) |=> (rdPtr == $past(rdNext)));

  // R7
  byte_lane_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sramWe && busWidth8) |-> $onehot(sramBe));

  // R11
  we_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    sramWe |-> (wrA && (index == 8'hF6 || index == 8'hF8)));

  // R11
  reset_out_chk: assert property (@(posedge clk)
    !rstN |-> (hostDout == 16'h0 && !sramWe));
endmodule

bind pktbuf_index_port pktbuf_index_port_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .busWidth8(busWidth8), .csN(csN), .rdN(rdN),
  .wrN(wrN), .cmdSel(cmdSel), .index(index), .rdPtr(rdPtr), .wrPtr(wrPtr),
  .sramWe(sramWe), .sramBe(sramBe), .hostDout(hostDout)
);

// File: tb/pktbuf_index_port_bench.sv
module pktbuf_index_port_bench;
  localparam int ADDR_W = 12;
  localparam int WORDS  = 1 << (ADDR_W - 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWidth8 = 1'b0;
  logic csN = 1'b1, rdN = 1'b1, wrN = 1'b1, cmdSel = 1'b0;
  logic [15:0] hostDin = '0;
  logic [15:0] hostDout;
  logic [ADDR_W-2:0] sramAddr;
  logic sramWe;
  logic [1:0] sramBe;
  logic [15:0] sramWdata;
  logic [15:0] sramRdata = '0;
  logic [15:0] mem [WORDS];

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pktbuf_index_port #(.ADDR_W(ADDR_W), .STUB_DEPTH(16)) u_pktbuf_index_port (
    .clk(clk), .rstN(rstN), .busWidth8(busWidth8), .csN(csN), .rdN(rdN),
    .wrN(wrN), .cmdSel(cmdSel), .hostDin(hostDin), .hostDout(hostDout),
    .sramAddr(sramAddr), .sramWe(sramWe), .sramBe(sramBe),
    .sramWdata(sramWdata), .sramRdata(sramRdata)
  );

  initial for (int i = 0; i < WORDS; i++) mem[i] = '0;

  always @(posedge clk) begin
    if (sramWe) begin
      if (sramBe[0]) mem[sramAddr][7:0]  <= sramWdata[7:0];
      if (sramBe[1]) mem[sramAddr][15:8] <= sramWdata[15:8];
    end
    sramRdata <= mem[sramAddr];
  end

  // fields: cmd, write, check, data, expected, requirement number
  localparam int NV = 34;
  localparam logic [38:0] VEC [NV] = '{
    {1'b0,1'b1,1'b0,16'h00FA,16'h0000,4'd1},  // R1 offset FA
    {1'b1,1'b1,1'b0,16'h0010,16'h0000,4'd6},  // R6 wrPtr low
    {1'b0,1'b1,1'b0,16'h00FB,16'h0000,4'd1},
    {1'b1,1'b1,1'b0,16'h0000,16'h0000,4'd6},
    {1'b0,1'b1,1'b0,16'h00F8,16'h0000,4'd3},
    {1'b1,1'b1,1'b0,16'h1111,16'h0000,4'd3},  // R3 store 0x10
    {1'b1,1'b1,1'b0,16'h2222,16'h0000,4'd3},  // R3 store 0x12
    {1'b0,1'b1,1'b0,16'h00F6,16'h0000,4'd2},
    {1'b1,1'b1,1'b0,16'h3333,16'h0000,4'd2},  // R2 store 0x14
    {1'b1,1'b1,1'b0,16'h4444,16'h0000,4'd2},  // R2 overwrite 0x14
    {1'b0,1'b1,1'b0,16'h00FA,16'h0000,4'd3},
    {1'b1,1'b0,1'b1,16'h0000,16'h0014,4'd3},  // R3 pointer moved by 4
    {1'b0,1'b1,1'b0,16'h00F4,16'h0000,4'd6},
    {1'b1,1'b1,1'b0,16'h0010,16'h0000,4'd6},
    {1'b0,1'b1,1'b0,16'h00F0,16'h0000,4'd4},
    {1'b1,1'b0,1'b1,16'h0000,16'h1111,4'd4},  // R4 peek
    {1'b1,1'b0,1'b1,16'h0000,16'h1111,4'd4},  // R4 peek again
    {1'b0,1'b1,1'b0,16'h00F2,16'h0000,4'd5},
    {1'b1,1'b0,1'b1,16'h0000,16'h1111,4'd5},  // R5 same location after peek
    {1'b1,1'b0,1'b1,16'h0000,16'h2222,4'd5},
    {1'b1,1'b0,1'b1,16'h0000,16'h4444,4'd2},  // R2 overwrite seen
    {1'b0,1'b1,1'b0,16'h00F4,16'h0000,4'd7},
    {1'b1,1'b0,1'b1,16'h0000,16'h0016,4'd7},  // R7 step of 2
    {1'b0,1'b0,1'b1,16'h0000,16'h00F4,4'd1},  // R1 index readback
    {1'b0,1'b1,1'b0,16'h0003,16'h0000,4'd9},
    {1'b1,1'b1,1'b0,16'hAB5A,16'h0000,4'd9},
    {1'b1,1'b0,1'b1,16'h0000,16'h005A,4'd9},  // R9 stub readback
    {1'b0,1'b1,1'b0,16'h0040,16'h0000,4'd10},
    {1'b1,1'b1,1'b0,16'h0077,16'h0000,4'd10},
    {1'b1,1'b0,1'b1,16'h0000,16'h0000,4'd10}, // R10 reads zero
    {1'b0,1'b1,1'b0,16'h00F1,16'h0000,4'd10},
    {1'b1,1'b0,1'b1,16'h0000,16'h0000,4'd10}, // R10 F1 reads zero
    {1'b0,1'b1,1'b0,16'h00F4,16'h0000,4'd10},
    {1'b1,1'b0,1'b1,16'h0000,16'h0016,4'd10}  // R10 pointer untouched
  };

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic cmd, input logic wr, input logic [15:0] d);
    @(negedge clk);
    cmdSel = cmd; hostDin = d; csN = 1'b0;
    if (wr) wrN = 1'b0; else rdN = 1'b0;
    @(negedge clk);
    csN = 1'b1; wrN = 1'b1; rdN = 1'b1;
    @(negedge clk);
  endtask

  task automatic setReg(input logic [7:0] ofs, input logic [15:0] d);
    access(1'b0, 1'b1, {8'h00, ofs});
    access(1'b1, 1'b1, d);
  endtask

  task automatic readReg(input logic [7:0] ofs, input logic [15:0] exp, input string tag);
    access(1'b0, 1'b1, {8'h00, ofs});
    access(1'b1, 1'b0, 16'h0);
    check(hostDout, exp, tag);
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(hostDout, 16'h0000, "R11 dout in reset");
    rstN = 1'b1;
    readReg(8'hF4, 16'h0000, "R6 rdPtr low reset");
    readReg(8'hFB, 16'h0000, "R6 wrPtr high reset");

    for (int i = 0; i < NV; i++) begin
      access(VEC[i][38], VEC[i][37], VEC[i][35:20]);
      if (VEC[i][36]) check(hostDout, VEC[i][19:4], $sformatf("R%0d vector %0d", VEC[i][3:0], i));
    end

    // R11 reset clears output and index; switch to 8-bit bus during reset
    @(negedge clk); rstN = 1'b0; busWidth8 = 1'b1;
    repeat (2) @(negedge clk);
    check(hostDout, 16'h0000, "R11 dout after reset");
    rstN = 1'b1;
    access(1'b0, 1'b0, 16'h0);
    check(hostDout, 16'h0000, "R11 index after reset");
    readReg(8'h03, 16'h0000, "R9 stub reset");
    readReg(8'hFA, 16'h0000, "R6 wrPtr low reset");

    // R7 8-bit byte lanes and unit step
    setReg(8'hF4, 16'h0010);
    readReg(8'hF0, 16'h0011, "R7 peek low lane");
    access(1'b0, 1'b1, 16'h00F2);
    access(1'b1, 1'b0, 16'h0); check(hostDout, 16'h0011, "R7 pop byte 0x10");
    access(1'b1, 1'b0, 16'h0); check(hostDout, 16'h0011, "R7 pop byte 0x11");
    access(1'b1, 1'b0, 16'h0); check(hostDout, 16'h0022, "R7 pop byte 0x12");
    readReg(8'hF4, 16'h0013, "R7 step of 1");
    setReg(8'hFA, 16'h0020);
    access(1'b0, 1'b1, 16'h00F8);
    access(1'b1, 1'b1, 16'h00AB);
    access(1'b1, 1'b1, 16'h00CD);
    setReg(8'hF4, 16'h0020);
    access(1'b0, 1'b1, 16'h00F2);
    access(1'b1, 1'b0, 16'h0); check(hostDout, 16'h00AB, "R7 byte write low lane");
    access(1'b1, 1'b0, 16'h0); check(hostDout, 16'h00CD, "R7 byte write high lane");

    // R8 wrap of both pointers
    setReg(8'hFA, 16'h00FF);
    setReg(8'hFB, 16'h000F);
    access(1'b0, 1'b1, 16'h00F8);
    access(1'b1, 1'b1, 16'h005C);
    readReg(8'hFA, 16'h0000, "R8 wrPtr wrap low");
    readReg(8'hFB, 16'h0000, "R8 wrPtr wrap high");
    setReg(8'hF4, 16'h00FF);
    setReg(8'hF5, 16'h00FF);
    readReg(8'hF5, 16'h000F, "R6 bits above ADDR_W read zero");
    readReg(8'hF2, 16'h005C, "R8 read at top byte");
    readReg(8'hF4, 16'h0000, "R8 rdPtr wrap low");
    readReg(8'hF5, 16'h0000, "R8 rdPtr wrap high");

    // R10 write to unused offset leaves stub and pointers alone
    setReg(8'h05, 16'h0033);
    setReg(8'h80, 16'h0099);
    readReg(8'h05, 16'h0033, "R10 stub unaffected");
    readReg(8'h80, 16'h0000, "R10 unused reads zero");

    report();
  end
endmodule